// File: doc/BRIEF.md
# Banked Card ROM/RAM Window Mapper

This block sits on an 8-bit host peripheral bus and maps two on-chip memories into small host-visible windows. An 8 KB ROM is seen through a 2 KB window and a 2 KB RAM through a 512-byte window. Each memory is split into four banks, and a two-bit bank register chooses which bank the window shows. The host decodes which window a cycle targets and presents one of four mutually exclusive selects: ROM window, RAM window, card configuration register, or disk controller register space.

The RAM bank is loaded by any write to the configuration register. The ROM bank is loaded by a write to the disk controller register space, but only while the controller's live motor latch is clear. The motor output that stays on through the spin-down period plays no part in this decision. A write that arrives while the latch is set still goes on to the disk controller, but it leaves the ROM bank where it was. A bank chosen from the wrong motor signal would send a code fetch to the right offset in the wrong bank, so this gating has to be exact.

The ROM image is a placeholder generated from the address. Reads return registered data one clock after the strobe.

Top module: `card_mem_map`

## Requirements
- R1: After reset, rom_bank_o is 0, ram_bank_o is 0 and rdata_o is 0x00.
- R2: A read strobe with rom_sel_i set returns a byte on rdata_o after the next rising clock edge. Let A = rom_bank_o*2048 + addr_i[10:0]. The byte is A[7:0] XOR A[15:8] XOR 0x5A.
- R3: A write strobe with ctl_sel_i set, while motor_latch_i is 0, loads rom_bank_o from wdata_i[1:0] at that clock edge.
- R4: A write strobe with ctl_sel_i set, while motor_latch_i is 1, leaves rom_bank_o and the visible ROM bank unchanged.
- R5: ctl_wr_o is high in exactly those cycles that carry a write strobe with ctl_sel_i set, whatever the value of motor_latch_i. Reads of the controller space leave it low.
- R6: A write strobe with cfg_sel_i set loads ram_bank_o from wdata_i[1:0], whatever the value of motor_latch_i.
- R7: A write strobe with ram_sel_i set stores wdata_i at RAM location ram_bank_o*512 + addr_i[8:0] at that clock edge. A later read in the same bank and at the same offset returns the stored byte one clock after its strobe. The four banks hold independent data.
- R8: rdata_o changes only after a read strobe. Write strobes and idle cycles leave it unchanged.
- R9: A write strobe with rom_sel_i set changes neither the ROM contents nor either bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Host bus cycle strobe, one clock per access |
| rd_i | input | 1 | 1 = read, 0 = write |
| rom_sel_i | input | 1 | ROM window select |
| ram_sel_i | input | 1 | RAM window select |
| cfg_sel_i | input | 1 | Card configuration register select (RAM bank) |
| ctl_sel_i | input | 1 | Disk controller register space select |
| motor_latch_i | input | 1 | Live, undelayed motor latch from the disk controller |
| addr_i | input | 11 | Offset within the selected window |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| rom_bank_o | output | 2 | Current ROM bank |
| ram_bank_o | output | 2 | Current RAM bank |
| ctl_wr_o | output | 1 | Write pass-through strobe to the disk controller |

## Verification
The ROM is read at the first, a middle and the last offset in every bank. Because the generated byte depends on the bank bits, a bank decode that is wrong or stuck shows up as a data mismatch rather than slipping through unseen. Controller writes are issued with the motor latch set and with it clear, and ctl_wr_o is watched during the strobe. This separates a gate that blocks the bank load from one that also blocks the pass-through. Each RAM bank is filled with its own pattern before any of them is read back, so aliasing between banks is caught. Writes to the ROM window and idle gaps between reads confirm that neither alters state or output data.

// File: rtl/card_mem_pkg.sv
package card_mem_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] ROM_SEED = 8'h5A;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_ROM,
    ACC_RAM,
    ACC_CFG,
    ACC_CTL
  } acc_e;

  typedef struct packed {
    logic rom_rd;
    logic ram_rd;
    logic ram_wr;
    logic cfg_wr;
    logic ctl_wr;
  } acc_strb_t;
endpackage

// File: rtl/card_mem_decode.sv
module card_mem_decode
  import card_mem_pkg::*;
(
  input  logic      strobe_i,
  input  logic      rd_i,
  input  logic      rom_sel_i,
  input  logic      ram_sel_i,
  input  logic      cfg_sel_i,
  input  logic      ctl_sel_i,
  output acc_strb_t strb_o
);
  acc_e kind;

  // fixed priority guards against overlapping selects
  always_comb begin
    if (rom_sel_i)      kind = ACC_ROM;
    else if (ram_sel_i) kind = ACC_RAM;
    else if (cfg_sel_i) kind = ACC_CFG;
    else if (ctl_sel_i) kind = ACC_CTL;
    else                kind = ACC_NONE;
  end

  always_comb begin
    strb_o        = '0;
    strb_o.rom_rd = strobe_i &  rd_i & (kind == ACC_ROM);
    strb_o.ram_rd = strobe_i &  rd_i & (kind == ACC_RAM);
    strb_o.ram_wr = strobe_i & ~rd_i & (kind == ACC_RAM);
    strb_o.cfg_wr = strobe_i & ~rd_i & (kind == ACC_CFG);
    strb_o.ctl_wr = strobe_i & ~rd_i & (kind == ACC_CTL);
  end
endmodule

// File: rtl/card_mem_banks.sv
module card_mem_banks #(
  parameter int ROM_BW = 2,
  parameter int RAM_BW = 2,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              cfg_wr_i,
  input  logic              motor_latch_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [ROM_BW-1:0] rom_bank_o,
  output logic [RAM_BW-1:0] ram_bank_o
);
  // live latch only; the spin-down motor output must not gate this
  logic rom_ld;
  assign rom_ld = ctl_wr_i & ~motor_latch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_o <= '0;
      ram_bank_o <= '0;
    end else begin
      if (rom_ld)   rom_bank_o <= wdata_i[ROM_BW-1:0];
      if (cfg_wr_i) ram_bank_o <= wdata_i[RAM_BW-1:0];
    end
  end
endmodule

// File: rtl/card_mem_rom.sv
module card_mem_rom #(
  parameter int AW = 13,
  parameter int DW = 8,
  parameter logic [DW-1:0] SEED = 8'h5A
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  // placeholder image: low byte ^ next byte ^ seed
  logic [31:0] a_ext;
  logic [31:0] a_hi;
  assign a_ext  = 32'(addr_i);
  assign a_hi   = a_ext >> DW;
  assign data_o = a_ext[DW-1:0] ^ a_hi[DW-1:0] ^ SEED;
endmodule

// File: rtl/card_mem_ram.sv
module card_mem_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/card_mem_map.sv
module card_mem_map
  import card_mem_pkg::*;
#(
  parameter int ROM_BYTES = 8192,
  parameter int ROM_WIN   = 2048,
  parameter int RAM_BYTES = 2048,
  parameter int RAM_WIN   = 512,
  localparam int DW       = DATA_W,
  localparam int AW       = $clog2(ROM_WIN),
  localparam int ROM_BW   = $clog2(ROM_BYTES / ROM_WIN),
  localparam int RAM_BW   = $clog2(RAM_BYTES / RAM_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rd_i,
  input  logic              rom_sel_i,
  input  logic              ram_sel_i,
  input  logic              cfg_sel_i,
  input  logic              ctl_sel_i,
  input  logic              motor_latch_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [ROM_BW-1:0] rom_bank_o,
  output logic [RAM_BW-1:0] ram_bank_o,
  output logic              ctl_wr_o
);
  localparam int ROM_OW = $clog2(ROM_WIN);
  localparam int RAM_OW = $clog2(RAM_WIN);
  localparam int ROM_AW = ROM_BW + ROM_OW;
  localparam int RAM_AW = RAM_BW + RAM_OW;

  acc_strb_t strb;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic [DW-1:0]     rom_data;
  logic [DW-1:0]     ram_data;

  card_mem_decode u_decode (
    .strobe_i  (strobe_i),
    .rd_i      (rd_i),
    .rom_sel_i (rom_sel_i),
    .ram_sel_i (ram_sel_i),
    .cfg_sel_i (cfg_sel_i),
    .ctl_sel_i (ctl_sel_i),
    .strb_o    (strb)
  );

  card_mem_banks #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW), .DW(DW)) u_banks (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctl_wr_i      (strb.ctl_wr),
    .cfg_wr_i      (strb.cfg_wr),
    .motor_latch_i (motor_latch_i),
    .wdata_i       (wdata_i),
    .rom_bank_o    (rom_bank_o),
    .ram_bank_o    (ram_bank_o)
  );

  assign rom_addr = {rom_bank_o, addr_i[ROM_OW-1:0]};
  assign ram_addr = {ram_bank_o, addr_i[RAM_OW-1:0]};

  card_mem_rom #(.AW(ROM_AW), .DW(DW), .SEED(ROM_SEED)) u_rom (
    .addr_i (rom_addr),
    .data_o (rom_data)
  );

  card_mem_ram #(.DEPTH(RAM_BYTES), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (strb.ram_wr),
    .waddr_i (ram_addr),
    .wdata_i (wdata_i),
    .raddr_i (ram_addr),
    .rdata_o (ram_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdata_o <= '0;
    else if (strb.rom_rd) rdata_o <= rom_data;
    else if (strb.ram_rd) rdata_o <= ram_data;
  end

  // pass-through regardless of motor state
  assign ctl_wr_o = strb.ctl_wr;
endmodule

// File: rtl/card_mem_map_chk.sv
module card_mem_map_chk #(
  parameter int ROM_WIN = 2048,
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int ROM_BW  = 2,
  parameter int RAM_BW  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              rd_i,
  input logic              rom_sel_i,
  input logic              ram_sel_i,
  input logic              cfg_sel_i,
  input logic              ctl_sel_i,
  input logic              motor_latch_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [ROM_BW-1:0] rom_bank_o,
  input logic [RAM_BW-1:0] ram_bank_o,
  input logic              ctl_wr_o
);
  logic ctl_w, cfg_w, rom_r, any_rd;
  assign ctl_w  = strobe_i & ~rd_i & ctl_sel_i & ~rom_sel_i & ~ram_sel_i & ~cfg_sel_i;
  assign cfg_w  = strobe_i & ~rd_i & cfg_sel_i & ~rom_sel_i & ~ram_sel_i;
  assign rom_r  = strobe_i & rd_i & rom_sel_i;
  assign any_rd = strobe_i & rd_i;

  function automatic logic [DW-1:0] exp_rom(input logic [ROM_BW-1:0] b,
                                            input logic [AW-1:0] off);
    logic [31:0] lin;
    logic [31:0] hi;
    lin = 32'(b) * 32'(ROM_WIN) + 32'(off);
    hi  = lin >> DW;
    return lin[DW-1:0] ^ hi[DW-1:0] ^ 8'h5A;
  endfunction

  a_r2_rom_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_r |=> rdata_o == exp_rom($past(rom_bank_o), $past(addr_i)));

  a_r3_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && !motor_latch_i) |=> rom_bank_o == $past(wdata_i[ROM_BW-1:0]));

  a_r4_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_w && !motor_latch_i) |=> $stable(rom_bank_o));

  a_r5_ctl_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_w |-> ctl_wr_o);

  a_r5_ctl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_w |-> !ctl_wr_o);

  a_r6_ram_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_w |=> ram_bank_o == $past(wdata_i[RAM_BW-1:0]));

  a_r8_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_rd |=> $stable(rdata_o));
endmodule

bind card_mem_map card_mem_map_chk #(
  .ROM_WIN (ROM_WIN),
  .AW      (AW),
  .DW      (DW),
  .ROM_BW  (ROM_BW),
  .RAM_BW  (RAM_BW)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .strobe_i      (strobe_i),
  .rd_i          (rd_i),
  .rom_sel_i     (rom_sel_i),
  .ram_sel_i     (ram_sel_i),
  .cfg_sel_i     (cfg_sel_i),
  .ctl_sel_i     (ctl_sel_i),
  .motor_latch_i (motor_latch_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .rom_bank_o    (rom_bank_o),
  .ram_bank_o    (ram_bank_o),
  .ctl_wr_o      (ctl_wr_o)
);

// File: tb/card_mem_map_tb.sv
`timescale 1ns/1ps
module card_mem_map_tb;
  localparam int SEL_ROM = 0;
  localparam int SEL_RAM = 1;
  localparam int SEL_CFG = 2;
  localparam int SEL_CTL = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe, rd, rom_sel, ram_sel, cfg_sel, ctl_sel, motor;
  logic [10:0] addr;
  logic [7:0]  wdata, rdata;
  logic [1:0]  rom_bank, ram_bank;
  logic        ctl_wr;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  card_mem_map u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .rd_i(rd),
    .rom_sel_i(rom_sel), .ram_sel_i(ram_sel), .cfg_sel_i(cfg_sel),
    .ctl_sel_i(ctl_sel), .motor_latch_i(motor), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rom_bank_o(rom_bank),
    .ram_bank_o(ram_bank), .ctl_wr_o(ctl_wr)
  );

  function automatic logic [7:0] rom_exp(input int bank, input int off);
    int lin;
    lin = bank * 2048 + off;
    return 8'(lin) ^ 8'(lin >> 8) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_sel(input int s);
    rom_sel = (s == SEL_ROM);
    ram_sel = (s == SEL_RAM);
    cfg_sel = (s == SEL_CFG);
    ctl_sel = (s == SEL_CTL);
  endtask

  task automatic idle();
    strobe = 0; rd = 1; rom_sel = 0; ram_sel = 0; cfg_sel = 0; ctl_sel = 0;
  endtask

  // write: drive at negedge, strobe across one posedge; returns ctl_wr seen mid-strobe
  task automatic bus_wr(input int s, input int a, input int d, output logic pass);
    @(negedge clk);
    set_sel(s); strobe = 1; rd = 0; addr = 11'(a); wdata = 8'(d);
    #1 pass = ctl_wr;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_rd(input int s, input int a, output logic [7:0] q, output logic pass);
    @(negedge clk);
    set_sel(s); strobe = 1; rd = 1; addr = 11'(a);
    #1 pass = ctl_wr;
    @(negedge clk);
    idle();
    q = rdata;
  endtask

  task automatic t_reset();
    chk("R1 rom_bank", rom_bank, 0);
    chk("R1 ram_bank", ram_bank, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_rom_banks();
    logic p;
    logic [7:0] q;
    motor = 0;
    for (int b = 0; b < 4; b++) begin
      bus_wr(SEL_CTL, 0, 8'hF0 | b, p);
      chk("R3 bank load", rom_bank, b);
      bus_rd(SEL_ROM, 11'h000, q, p); chk("R2 rom first", q, rom_exp(b, 0));
      bus_rd(SEL_ROM, 11'h123, q, p); chk("R2 rom mid", q, rom_exp(b, 11'h123));
      bus_rd(SEL_ROM, 11'h7FF, q, p); chk("R2 rom last", q, rom_exp(b, 11'h7FF));
    end
  endtask

  task automatic t_motor_gate();
    logic p;
    logic [7:0] q;
    motor = 0;
    bus_wr(SEL_CTL, 5, 1, p);
    chk("R5 ctl pass latch clear", p, 1);
    chk("R3 bank=1", rom_bank, 1);
    motor = 1;
    bus_wr(SEL_CTL, 6, 3, p);
    chk("R5 ctl pass latch set", p, 1);
    chk("R4 bank held", rom_bank, 1);
    bus_rd(SEL_ROM, 11'h010, q, p);
    chk("R4 window still bank1", q, rom_exp(1, 11'h010));
    bus_rd(SEL_CTL, 6, q, p);
    chk("R5 ctl read quiet", p, 0);
    bus_wr(SEL_RAM, 0, 8'h00, p);
    chk("R5 ram write quiet", p, 0);
    motor = 0;
    bus_wr(SEL_CTL, 6, 3, p);
    chk("R3 bank=3 after latch clear", rom_bank, 3);
  endtask

  task automatic t_ram();
    logic p;
    logic [7:0] q;
    motor = 1;
    for (int b = 0; b < 4; b++) begin
      bus_wr(SEL_CFG, 0, b, p);
      chk("R6 ram bank", ram_bank, b);
      bus_wr(SEL_RAM, 11'h000, 8'h11 * (b + 1), p);
      bus_wr(SEL_RAM, 11'h1FF, 8'hA0 ^ b, p);
      bus_wr(SEL_RAM, 11'h0C3, 8'h3C + b, p);
    end
    motor = 0;
    for (int b = 3; b >= 0; b--) begin
      bus_wr(SEL_CFG, 0, b, p);
      bus_rd(SEL_RAM, 11'h000, q, p); chk("R7 ram first", q, 8'(8'h11 * (b + 1)));
      bus_rd(SEL_RAM, 11'h1FF, q, p); chk("R7 ram last", q, 8'hA0 ^ b);
      bus_rd(SEL_RAM, 11'h0C3, q, p); chk("R7 ram mid", q, 8'(8'h3C + b));
    end
  endtask

  task automatic t_hold();
    logic p;
    logic [7:0] q;
    bus_rd(SEL_ROM, 11'h2A5, q, p);
    chk("R8 read", q, rom_exp(3, 11'h2A5));
    bus_wr(SEL_ROM, 11'h2A5, 8'h00, p);
    chk("R8 held after rom write", rdata, rom_exp(3, 11'h2A5));
    chk("R9 rom bank", rom_bank, 3);
    chk("R9 ram bank", ram_bank, 0);
    repeat (3) @(negedge clk);
    chk("R8 held idle", rdata, rom_exp(3, 11'h2A5));
    bus_wr(SEL_RAM, 11'h044, 8'h77, p);
    chk("R8 held after ram write", rdata, rom_exp(3, 11'h2A5));
    bus_rd(SEL_ROM, 11'h2A5, q, p);
    chk("R9 rom unchanged", q, rom_exp(3, 11'h2A5));
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(); motor = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_rom_banks();
    t_motor_gate();
    t_ram();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule